// File: doc/BRIEF.md
# Transmit Descriptor Pointer Controller

This block keeps two addresses for a transmit DMA engine. The first is the software-programmed base of the descriptor list. The second is the engine's working pointer to the descriptor it is currently handling. Software programs the base through a plain write port and can read it back. A run-enable level starts and stops the engine. While the engine runs, a one-cycle step pulse moves the working pointer to the next descriptor. The aligned working pointer is driven out as the address for descriptor fetches.

Base writes are accepted only while the engine is stopped. An accepted write marks the base as pending. On the next rising edge of run-enable, a pending base is copied into the working pointer. If no write was accepted during the stop, the working pointer resumes from the place where the engine halted. The low address bits are forced to zero to match the data bus width, which is set by a parameter.

Top module: `txdesc_ptr_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` and `desc_addr` are both zero.
- R2: The low address bits are always zero on `cfg_rd_data` and `desc_addr`, and the corresponding bits of `cfg_wr_data` are ignored. The masked bits are [1:0] when BUS_BYTES=4, [2:0] when BUS_BYTES=8, and [3:0] when BUS_BYTES=16.
- R3: A write while `run_en` is 1 is dropped. After it, neither `cfg_rd_data` nor `desc_addr` has changed.
- R4: A rising edge of `run_en` (0 in the previous cycle, 1 now) that follows an accepted write makes `desc_addr` equal to the new base from the next cycle on.
- R5: A rising edge of `run_en` with no write accepted since the previous start leaves `desc_addr` at the address held when the engine stopped.
- R6: When `run_en` has been 1 for at least one earlier cycle, a `step` pulse adds STRIDE_BYTES to `desc_addr` in the next cycle. A `step` in the cycle of the rising edge itself is ignored.
- R7: While `run_en` is 0, `desc_addr` holds its value and `step` has no effect.
- R8: `cfg_rd_data` returns the aligned programmed base, not the working pointer.
- R9: If several writes are accepted during one stop, the last one is used. One start edge consumes the pending base, so a later stop/start with no write resumes in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Base write strobe |
| cfg_wr_data | input | ADDR_W | Base write data |
| cfg_rd_data | output | ADDR_W | Aligned programmed base |
| run_en | input | 1 | Engine run level (1 = running) |
| step | input | 1 | Advance to next descriptor |
| desc_addr | output | ADDR_W | Aligned working descriptor address |

## Verification
The hardest case to reach is the choice between reload and resume on a restart. To tell the two apart, the working pointer must first be moved away from the base by steps. The engine is then stopped and restarted, once with a base write during the stop and once without. The bench also writes twice during a single stop, then follows with a second stop/start that has no write, to show the pending mark is used up. A step issued together with the start edge covers the priority of reload over advance.

// File: rtl/txdp_pkg.sv
package txdp_pkg;
   // number of address bits below the bus word
   function automatic int lsb_bits(input int bus_bytes);
      int n;
      n = 0;
      while ((1 << n) < bus_bytes) n++;
      return n;
   endfunction

   function automatic bit legal_bus(input int bus_bytes);
      return (bus_bytes == 4) || (bus_bytes == 8) || (bus_bytes == 16);
   endfunction
endpackage

// File: rtl/txdp_align.sv
module txdp_align #(
   parameter int ADDR_W    = 32,
   parameter int BUS_BYTES = 4
) (
   input  logic [ADDR_W-1:0] in_addr,
   output logic [ADDR_W-1:0] out_addr
);
   localparam int LSB_W = txdp_pkg::lsb_bits(BUS_BYTES);

   if (!txdp_pkg::legal_bus(BUS_BYTES)) begin : g_bad_bus
      $error("txdp_align: BUS_BYTES must be 4, 8 or 16");
   end

   if (BUS_BYTES == 4) begin : g_w32
      assign out_addr = {in_addr[ADDR_W-1:2], 2'b00};
   end else if (BUS_BYTES == 8) begin : g_w64
      assign out_addr = {in_addr[ADDR_W-1:3], 3'b000};
   end else begin : g_w128
      assign out_addr = {in_addr[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
   end
endmodule

// File: rtl/txdp_base_reg.sv
module txdp_base_reg #(
   parameter int ADDR_W    = 32,
   parameter int BUS_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              run_en,
   input  logic              start_edge,
   output logic [ADDR_W-1:0] base_o,
   output logic              pend_o
);
   logic [ADDR_W-1:0] wr_aligned;
   logic              accept;

   txdp_align #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_wr_align (
      .in_addr  (wr_data),
      .out_addr (wr_aligned)
   );

   // writes land only while stopped
   assign accept = wr_en && !run_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_o <= '0;
         pend_o <= 1'b0;
      end else begin
         if (accept) begin
            base_o <= wr_aligned;
            pend_o <= 1'b1;
         end else if (start_edge) begin
            pend_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/txdp_walker.sv
module txdp_walker #(
   parameter int ADDR_W       = 32,
   parameter int STRIDE_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              step,
   input  logic [ADDR_W-1:0] base,
   input  logic              pend,
   output logic              start_edge_o,
   output logic [ADDR_W-1:0] ptr_o
);
   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(STRIDE_BYTES);

   logic run_q;
   logic running;

   assign start_edge_o = run_en && !run_q;
   assign running      = run_en && run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         ptr_o <= '0;
      end else begin
         run_q <= run_en;
         if (start_edge_o) begin
            if (pend) ptr_o <= base;
         end else if (running && step) begin
            ptr_o <= ptr_o + STRIDE;
         end
      end
   end
endmodule

// File: rtl/txdesc_ptr_ctrl.sv
module txdesc_ptr_ctrl #(
   parameter int ADDR_W       = 32,
   parameter int BUS_BYTES    = 4,
   parameter int STRIDE_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_wr_data,
   output logic [ADDR_W-1:0] cfg_rd_data,
   input  logic              run_en,
   input  logic              step,
   output logic [ADDR_W-1:0] desc_addr
);
   if (ADDR_W < 8) begin : g_bad_width
      $error("txdesc_ptr_ctrl: ADDR_W too small");
   end
   if ((STRIDE_BYTES % BUS_BYTES) != 0 || STRIDE_BYTES <= 0) begin : g_bad_stride
      $error("txdesc_ptr_ctrl: STRIDE_BYTES must be a positive multiple of BUS_BYTES");
   end

   logic [ADDR_W-1:0] base_q;
   logic              pend_q;
   logic              start_edge;
   logic [ADDR_W-1:0] ptr_q;

   txdp_base_reg #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_wr_en),
      .wr_data    (cfg_wr_data),
      .run_en     (run_en),
      .start_edge (start_edge),
      .base_o     (base_q),
      .pend_o     (pend_q)
   );

   txdp_walker #(.ADDR_W(ADDR_W), .STRIDE_BYTES(STRIDE_BYTES)) u_walk (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_en       (run_en),
      .step         (step),
      .base         (base_q),
      .pend         (pend_q),
      .start_edge_o (start_edge),
      .ptr_o        (ptr_q)
   );

   txdp_align #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_out_align (
      .in_addr  (ptr_q),
      .out_addr (desc_addr)
   );

   assign cfg_rd_data = base_q;
endmodule

// File: rtl/txdp_checker.sv
module txdp_checker #(
   parameter int ADDR_W       = 32,
   parameter int BUS_BYTES    = 4,
   parameter int STRIDE_BYTES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic [ADDR_W-1:0] cfg_rd_data,
   input logic              run_en,
   input logic              step,
   input logic [ADDR_W-1:0] desc_addr
);
   localparam int LSB_W = txdp_pkg::lsb_bits(BUS_BYTES);

   logic run_seen;
   logic wrote_in_stop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_seen      <= 1'b0;
         wrote_in_stop <= 1'b0;
      end else begin
         run_seen <= run_en;
         if (cfg_wr_en && !run_en) wrote_in_stop <= 1'b1;
         else if (run_en && !run_seen) wrote_in_stop <= 1'b0;
      end
   end

   p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rd_data[LSB_W-1:0] == '0) && (desc_addr[LSB_W-1:0] == '0));

   p_run_write_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(cfg_rd_data));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !run_seen && wrote_in_stop) |=> (desc_addr == $past(cfg_rd_data)));

   p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !run_seen && !wrote_in_stop) |=> $stable(desc_addr));

   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && run_seen && step) |=>
         (desc_addr == $past(desc_addr) + ADDR_W'(STRIDE_BYTES)));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(desc_addr));
endmodule

bind txdesc_ptr_ctrl txdp_checker #(
   .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .STRIDE_BYTES(STRIDE_BYTES)
) u_txdp_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_wr_en   (cfg_wr_en),
   .cfg_rd_data (cfg_rd_data),
   .run_en      (run_en),
   .step        (step),
   .desc_addr   (desc_addr)
);

// File: tb/test_txdesc_ptr_ctrl.sv
module test_txdesc_ptr_ctrl;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [AW-1:0] cfg_wr_data = '0;
   logic          run_en = 1'b0;
   logic          step = 1'b0;
   logic [AW-1:0] rd_n, addr_n, rd_w, addr_w;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;  // 250 MHz

   txdesc_ptr_ctrl #(.ADDR_W(AW), .BUS_BYTES(4), .STRIDE_BYTES(16)) i_txdesc_ptr_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(rd_n), .run_en(run_en), .step(step), .desc_addr(addr_n));

   txdesc_ptr_ctrl #(.ADDR_W(AW), .BUS_BYTES(16), .STRIDE_BYTES(32)) i_txdesc_ptr_ctrl_w128 (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_data(rd_w), .run_en(run_en), .step(step), .desc_addr(addr_w));

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   // drive at negedge, advance one edge, sample after it
   task automatic tick(input logic we, input logic [AW-1:0] wd, input logic run, input logic stp);
      @(negedge clk);
      cfg_wr_en = we; cfg_wr_data = wd; run_en = run; step = stp;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset;
      check("R1 rd", rd_n, '0);
      check("R1 addr", addr_n, '0);
   endtask

   task automatic t_mask;
      tick(1, 32'h2000_001F, 0, 0);
      check("R2 rd 32b bus", rd_n, 32'h2000_001C);
      check("R2 rd 128b bus", rd_w, 32'h2000_0010);
      check("R7 addr held while stopped", addr_n, '0);
   endtask

   task automatic t_start_reload;
      tick(0, '0, 1, 1);  // start edge with step: step ignored
      check("R4 reload", addr_n, 32'h2000_001C);
      check("R6 step on edge ignored", addr_n, 32'h2000_001C);
      check("R2 addr 128b bus", addr_w, 32'h2000_0010);
      check("R8 rd is base", rd_n, 32'h2000_001C);
   endtask

   task automatic t_step;
      tick(0, '0, 1, 1);
      check("R6 step1", addr_n, 32'h2000_002C);
      tick(0, '0, 1, 0);
      check("R6 no step", addr_n, 32'h2000_002C);
      tick(0, '0, 1, 1);
      check("R6 step2", addr_n, 32'h2000_003C);
      check("R8 rd unaffected by walk", rd_n, 32'h2000_001C);
   endtask

   task automatic t_run_write;
      tick(1, 32'h5555_0000, 1, 0);
      tick(0, '0, 1, 0);
      check("R3 rd kept", rd_n, 32'h2000_001C);
      check("R3 addr kept", addr_n, 32'h2000_003C);
   endtask

   task automatic t_stop_resume;
      tick(0, '0, 0, 0);
      tick(0, '0, 0, 1);
      check("R7 step ignored stopped", addr_n, 32'h2000_003C);
      tick(0, '0, 1, 0);
      check("R5 resume", addr_n, 32'h2000_003C);
      tick(0, '0, 1, 1);
      check("R6 step after resume", addr_n, 32'h2000_004C);
   endtask

   task automatic t_last_wins;
      tick(0, '0, 0, 0);
      tick(1, 32'h0000_1000, 0, 0);
      tick(1, 32'h0000_2002, 0, 0);
      check("R9 last write rd", rd_n, 32'h0000_2000);
      check("R7 addr held", addr_n, 32'h2000_004C);
      tick(0, '0, 1, 0);
      check("R9 last write loaded", addr_n, 32'h0000_2000);
      tick(0, '0, 1, 1);
      tick(0, '0, 0, 0);
      tick(0, '0, 1, 0);
      check("R9 pending consumed", addr_n, 32'h0000_2010);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_mask();
      t_start_reload();
      t_step();
      t_run_write();
      t_stop_resume();
      t_last_wins();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule